// File: doc/BRIEF.md
# March AB memory self-test sequencer

This block runs a fixed six-element march test on a one-bit-wide synchronous RAM whose depth is a parameter. A pulse on `start_i` launches the run. The controller then issues one memory operation per clock. Each element applies its whole operation list to one cell before it moves to the next address. An element ends after its last cell, and the next element then starts. Every read carries an expected value. The data returned one cycle later is compared against that value, and any mismatch counts as a detection.

The elements, numbered from 0, are as follows. Element 0 writes 1 and walks upward. Elements 1 and 2 walk downward: element 1 applies r1 w0 r0 w0 r0 and element 2 applies r0 w1 r1 w1 r1. Elements 3 and 4 repeat those same two lists walking upward. Element 5 reads back the 1 that element 4 leaves in every cell, walking upward. The downward order is the exact reverse of the upward order.

At the end of the run `done_o` pulses for one cycle. The verdict then stays on `pass_o` / `fail_o` until the next start. On a failure, the element, operation slot and address of the first detection are held. The memory port has fixed timing and no handshake. A write takes effect at the clock edge that ends the cycle in which it is issued. Read data must be valid in the cycle after `mem_re_o`. The RAM cannot stall the controller, so there is no back-pressure.

Top module: `mab_bist_ctrl`

## Requirements
- R1: After reset the block is idle. `busy_o`, `done_o`, `pass_o` and `fail_o` are 0, and neither `mem_we_o` nor `mem_re_o` is asserted.
- R2: Start is sampled at a clock edge while idle. `busy_o` then rises. `done_o` is high for exactly one cycle, 22*DEPTH+1 edges after the edge that accepted start, and `busy_o` is low in that cycle.
- R3: The operations issued follow the element lists above, in element order 0 to 5. A clean run therefore makes 9*DEPTH writes and 13*DEPTH reads.
- R4: Elements 1 and 2 visit addresses from DEPTH-1 down to 0. Elements 0, 3, 4 and 5 visit addresses from 0 up to DEPTH-1. All operations of an element finish on one address before the next address is used.
- R5: `mem_rdata_i` is compared in the cycle after `mem_re_o` with the expected bit of that read. A difference is a detection.
- R6: The first detection of a run sets `fail_o` and records its element (0..5) on `fail_elem_o`, its operation slot (0..4) on `fail_op_o` and its address on `fail_addr_o`. Later detections in the same run change none of these.
- R7: When `done_o` rises with no detection, `pass_o` goes to 1. `pass_o` and `fail_o` are never both 1. Both hold until the next accepted start, which clears them.
- R8: A start pulse while `busy_o` is high is ignored and does not change the run length.
- R9: `mem_we_o` and `mem_re_o` are never high together. Both are low whenever `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch a run when idle |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Last run had no detection |
| fail_o | output | 1 | Last run had a detection |
| fail_elem_o | output | 3 | Element of first detection |
| fail_op_o | output | 3 | Operation slot of first detection |
| fail_addr_o | output | AW | Address of first detection |
| mem_addr_o | output | AW | RAM address |
| mem_we_o | output | 1 | RAM write strobe |
| mem_wdata_o | output | 1 | RAM write bit |
| mem_re_o | output | 1 | RAM read strobe |
| mem_rdata_i | input | 1 | RAM read bit, valid one cycle after the strobe |

## Verification
The hardest case to reach is a detection that depends on where one cell sits relative to another as the walk direction changes. Two examples are a write to one address corrupting another cell that has already been visited, and a fault that hides until a later element walks the other way. The bench drives the block with a behavioural RAM into which it injects faults: stuck cells, and a coupling in which a given write to an aggressor address forces a victim cell. The aggressor and victim pairs are placed so that detection lands in elements 1, 2, 3 and 4 at slots worked out by hand. A two-fault case shows that only the first detection is kept.

// File: rtl/mab_pkg.sv
`timescale 1ns/1ps
package mab_pkg;
  localparam int NUM_ELEM = 6;
  localparam int OP_SLOTS = 6;
  localparam int ELEM_W   = $clog2(NUM_ELEM);
  localparam int OP_W     = $clog2(OP_SLOTS);

  typedef enum logic [1:0] {
    OP_END = 2'd0,
    OP_WR  = 2'd1,
    OP_RD  = 2'd2
  } op_kind_e;

  typedef struct packed {
    op_kind_e kind;
    logic     val;
  } march_op_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } ctrl_st_e;

  // Walk direction of an element: 1 means downward.
  function automatic logic elem_desc(input logic [ELEM_W-1:0] e);
    return (e == ELEM_W'(1)) || (e == ELEM_W'(2));
  endfunction
endpackage

// File: rtl/mab_op_rom.sv
`timescale 1ns/1ps
module mab_op_rom
  import mab_pkg::*;
(
  input  logic [ELEM_W-1:0] elem_i,
  input  logic [OP_W-1:0]   slot_i,
  output march_op_t         op_o
);
  logic first_bit;

  always_comb begin
    op_o.kind = OP_END;
    op_o.val  = 1'b0;
    // Elements 1 and 3 begin by reading 1; elements 2 and 4 begin by reading 0.
    first_bit = (elem_i == ELEM_W'(1)) || (elem_i == ELEM_W'(3));
    case (elem_i)
      ELEM_W'(0): begin
        if (slot_i == '0) begin
          op_o.kind = OP_WR;
          op_o.val  = 1'b1;
        end
      end
      ELEM_W'(1), ELEM_W'(2), ELEM_W'(3), ELEM_W'(4): begin
        if (slot_i < OP_W'(5)) begin
          op_o.kind = slot_i[0] ? OP_WR : OP_RD;
          op_o.val  = (slot_i == '0) ? first_bit : ~first_bit;
        end
      end
      ELEM_W'(5): begin
        if (slot_i == '0) begin
          op_o.kind = OP_RD;
          op_o.val  = 1'b1;
        end
      end
      default: op_o.kind = OP_END;
    endcase
  end
endmodule

// File: rtl/mab_addr_seq.sv
`timescale 1ns/1ps
module mab_addr_seq #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          desc_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic          dir_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      addr_q <= '0;
    end else if (load_i) begin
      dir_q  <= desc_i;
      addr_q <= desc_i ? TOP : '0;
    end else if (step_i) begin
      addr_q <= dir_q ? addr_q - 1'b1 : addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign last_o = dir_q ? (addr_q == '0) : (addr_q == TOP);
endmodule

// File: rtl/mab_fail_log.sv
`timescale 1ns/1ps
module mab_fail_log
  import mab_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              rd_i,
  input  logic              exp_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic [OP_W-1:0]   slot_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              rdata_i,
  output logic              fail_o,
  output logic              fail_nxt_o,
  output logic [ELEM_W-1:0] fail_elem_o,
  output logic [OP_W-1:0]   fail_slot_o,
  output logic [AW-1:0]     fail_addr_o
);
  logic              pend_q, exp_q, fail_q, hit;
  logic [ELEM_W-1:0] tag_elem_q, fail_elem_q;
  logic [OP_W-1:0]   tag_slot_q, fail_slot_q;
  logic [AW-1:0]     tag_addr_q, fail_addr_q;

  assign hit        = pend_q && (rdata_i != exp_q);
  assign fail_nxt_o = fail_q || hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      exp_q       <= 1'b0;
      tag_elem_q  <= '0;
      tag_slot_q  <= '0;
      tag_addr_q  <= '0;
      fail_q      <= 1'b0;
      fail_elem_q <= '0;
      fail_slot_q <= '0;
      fail_addr_q <= '0;
    end else begin
      pend_q <= rd_i;
      if (rd_i) begin
        exp_q      <= exp_i;
        tag_elem_q <= elem_i;
        tag_slot_q <= slot_i;
        tag_addr_q <= addr_i;
      end
      if (clear_i) begin
        fail_q      <= 1'b0;
        fail_elem_q <= '0;
        fail_slot_q <= '0;
        fail_addr_q <= '0;
      end else if (hit && !fail_q) begin
        fail_q      <= 1'b1;
        fail_elem_q <= tag_elem_q;
        fail_slot_q <= tag_slot_q;
        fail_addr_q <= tag_addr_q;
      end
    end
  end

  assign fail_o      = fail_q;
  assign fail_elem_o = fail_elem_q;
  assign fail_slot_o = fail_slot_q;
  assign fail_addr_o = fail_addr_q;
endmodule

// File: rtl/mab_bist_ctrl.sv
`timescale 1ns/1ps
module mab_bist_ctrl
  import mab_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [ELEM_W-1:0] fail_elem_o,
  output logic [OP_W-1:0]   fail_op_o,
  output logic [AW-1:0]     fail_addr_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_wdata_o,
  output logic              mem_re_o,
  input  logic              mem_rdata_i
);
  ctrl_st_e          state_q;
  logic [ELEM_W-1:0] elem_q;
  logic [OP_W-1:0]   slot_q;
  logic              done_q, pass_q;

  march_op_t         cur_op, nxt_op;
  logic              run, accept, op_end, elem_last, at_last;
  logic              seq_load, seq_desc, seq_step, fail_nxt;
  logic [AW-1:0]     addr;

  assign run       = (state_q == ST_RUN);
  assign accept    = (state_q == ST_IDLE) && start_i;
  assign op_end    = (nxt_op.kind == OP_END);
  assign elem_last = (elem_q == ELEM_W'(NUM_ELEM - 1));

  mab_op_rom u_rom_cur (.elem_i(elem_q), .slot_i(slot_q), .op_o(cur_op));
  mab_op_rom u_rom_nxt (.elem_i(elem_q), .slot_i(slot_q + 1'b1), .op_o(nxt_op));

  assign seq_load = accept || (run && op_end && at_last && !elem_last);
  assign seq_desc = accept ? elem_desc('0) : elem_desc(elem_q + 1'b1);
  assign seq_step = run && op_end && !at_last;

  mab_addr_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (seq_load),
    .desc_i (seq_desc),
    .step_i (seq_step),
    .addr_o (addr),
    .last_o (at_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      slot_q  <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            elem_q  <= '0;
            slot_q  <= '0;
            pass_q  <= 1'b0;
          end
        end
        ST_RUN: begin
          if (!op_end) begin
            slot_q <= slot_q + 1'b1;
          end else begin
            slot_q <= '0;
            if (at_last) begin
              if (elem_last) state_q <= ST_FLUSH;
              else           elem_q  <= elem_q + 1'b1;
            end
          end
        end
        ST_FLUSH: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          pass_q  <= !fail_nxt;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  mab_fail_log #(.AW(AW)) u_log (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (accept),
    .rd_i        (mem_re_o),
    .exp_i       (cur_op.val),
    .elem_i      (elem_q),
    .slot_i      (slot_q),
    .addr_i      (addr),
    .rdata_i     (mem_rdata_i),
    .fail_o      (fail_o),
    .fail_nxt_o  (fail_nxt),
    .fail_elem_o (fail_elem_o),
    .fail_slot_o (fail_op_o),
    .fail_addr_o (fail_addr_o)
  );

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign pass_o      = pass_q;
  assign mem_addr_o  = addr;
  assign mem_we_o    = run && (cur_op.kind == OP_WR);
  assign mem_re_o    = run && (cur_op.kind == OP_RD);
  assign mem_wdata_o = run && cur_op.val;
endmodule

// File: rtl/mab_bist_chk.sv
`timescale 1ns/1ps
module mab_bist_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          pass_o,
  input logic          fail_o,
  input logic [AW-1:0] fail_addr_o,
  input logic          mem_we_o,
  input logic          mem_re_o
);
  // R9
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_we_o && !mem_re_o));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R6
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !(start_i && !busy_o)) |=> (fail_o && $stable(fail_addr_o)));

  // R7
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));
endmodule

bind mab_bist_ctrl mab_bist_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .fail_o      (fail_o),
  .fail_addr_o (fail_addr_o),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o)
);

// File: tb/mab_bist_ctrl_tb.sv
`timescale 1ns/1ps
module mab_bist_ctrl_tb;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int RUN_LEN = 22 * DEPTH + 1;

  typedef struct packed {
    logic          s1_en; logic [AW-1:0] s1_a; logic s1_v;
    logic          s2_en; logic [AW-1:0] s2_a; logic s2_v;
    logic          c_en;  logic [AW-1:0] c_ag; logic [AW-1:0] c_vi;
    logic          c_wv;  logic          c_fv;
    logic          x_fail; logic [2:0] x_elem; logic [2:0] x_op; logic [AW-1:0] x_addr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0,4'd0,1'b0,  1'b0,4'd0,1'b0,  1'b0,4'd0,4'd0,1'b0,1'b0,  1'b0,3'd0,3'd0,4'd0},
    '{1'b1,4'd5,1'b0,  1'b0,4'd0,1'b0,  1'b0,4'd0,4'd0,1'b0,1'b0,  1'b1,3'd1,3'd0,4'd5},
    '{1'b1,4'd9,1'b1,  1'b0,4'd0,1'b0,  1'b0,4'd0,4'd0,1'b0,1'b0,  1'b1,3'd1,3'd2,4'd9},
    '{1'b1,4'd0,1'b1,  1'b0,4'd0,1'b0,  1'b0,4'd0,4'd0,1'b0,1'b0,  1'b1,3'd1,3'd2,4'd0},
    '{1'b1,4'd15,1'b0, 1'b0,4'd0,1'b0,  1'b0,4'd0,4'd0,1'b0,1'b0,  1'b1,3'd1,3'd0,4'd15},
    '{1'b0,4'd0,1'b0,  1'b0,4'd0,1'b0,  1'b1,4'd2,4'd7,1'b0,1'b1,  1'b1,3'd2,3'd0,4'd7},
    '{1'b0,4'd0,1'b0,  1'b0,4'd0,1'b0,  1'b1,4'd7,4'd2,1'b0,1'b1,  1'b1,3'd4,3'd0,4'd2},
    '{1'b0,4'd0,1'b0,  1'b0,4'd0,1'b0,  1'b1,4'd10,4'd4,1'b1,1'b0, 1'b1,3'd1,3'd0,4'd4},
    '{1'b0,4'd0,1'b0,  1'b0,4'd0,1'b0,  1'b1,4'd4,4'd10,1'b1,1'b0, 1'b1,3'd3,3'd0,4'd10},
    '{1'b1,4'd5,1'b0,  1'b1,4'd12,1'b0, 1'b0,4'd0,4'd0,1'b0,1'b0,  1'b1,3'd1,3'd0,4'd12}
  };

  logic clk = 1'b0;
  logic rst_n, start_i;
  logic busy_o, done_o, pass_o, fail_o;
  logic [2:0] fail_elem_o, fail_op_o;
  logic [AW-1:0] fail_addr_o, mem_addr_o;
  logic mem_we_o, mem_wdata_o, mem_re_o;
  logic mem_rdata_i = 1'b0;

  always #4 clk = ~clk;

  mab_bist_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o),
    .fail_elem_o(fail_elem_o), .fail_op_o(fail_op_o), .fail_addr_o(fail_addr_o),
    .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
    .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata_i)
  );

  int tests = 0;
  int fails = 0;
  vec_t flt;
  logic mem [DEPTH];
  int wcnt, rcnt, both_cnt;
  logic [AW-1:0] wlog [512];
  logic [AW-1:0] rlog [512];

  // Behavioural RAM with injectable faults.
  always @(posedge clk) begin
    if (mem_we_o) begin
      if (!((flt.s1_en && mem_addr_o == flt.s1_a) || (flt.s2_en && mem_addr_o == flt.s2_a)))
        mem[mem_addr_o] <= mem_wdata_o;
      if (flt.c_en && mem_addr_o == flt.c_ag && mem_wdata_o == flt.c_wv)
        mem[flt.c_vi] <= flt.c_fv;
    end
    if (mem_re_o) begin
      if (flt.s1_en && mem_addr_o == flt.s1_a)      mem_rdata_i <= flt.s1_v;
      else if (flt.s2_en && mem_addr_o == flt.s2_a) mem_rdata_i <= flt.s2_v;
      else                                          mem_rdata_i <= mem[mem_addr_o];
    end
  end

  always @(negedge clk) begin
    if (mem_we_o && mem_re_o) both_cnt++;
    if (!busy_o && (mem_we_o || mem_re_o)) both_cnt++;
    if (mem_we_o) begin if (wcnt < 512) wlog[wcnt] = mem_addr_o; wcnt++; end
    if (mem_re_o) begin if (rcnt < 512) rlog[rcnt] = mem_addr_o; rcnt++; end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input vec_t v, input bit mid_start, input string tag);
    int cnt;
    flt = v;
    for (int i = 0; i < DEPTH; i++) mem[i] = 1'b0;
    wcnt = 0; rcnt = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    cnt = 0;
    chk({tag, " R2 busy after start"}, busy_o, 1);
    chk({tag, " R7 verdict cleared by start"}, pass_o | fail_o, 0);
    while (!done_o && cnt < 2000) begin
      start_i = (mid_start && cnt == 100);
      @(negedge clk);
      cnt++;
    end
    start_i = 1'b0;
    chk({tag, " R2/R8 done timing"}, cnt, RUN_LEN);
    chk({tag, " R2 idle at done"}, busy_o, 0);
    chk({tag, " R5/R6 fail flag"}, fail_o, v.x_fail);
    chk({tag, " R7 pass flag"}, pass_o, !v.x_fail);
    if (v.x_fail) begin
      chk({tag, " R6 fail element"}, fail_elem_o, v.x_elem);
      chk({tag, " R6 fail slot"}, fail_op_o, v.x_op);
      chk({tag, " R6 fail address"}, fail_addr_o, v.x_addr);
    end
    @(negedge clk);
    chk({tag, " R2 done one cycle"}, done_o, 0);
    repeat (3) @(negedge clk);
    chk({tag, " R7 verdict held"}, {pass_o, fail_o}, {!v.x_fail, v.x_fail});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    flt = '0;
    both_cnt = 0; wcnt = 0; rcnt = 0;
    rst_n = 1'b0; start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset busy/done", {busy_o, done_o}, 0);
    chk("R1 reset verdict", {pass_o, fail_o}, 0);
    chk("R1/R9 reset memory strobes", {mem_we_o, mem_re_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", busy_o, 0);

    for (int i = 0; i < NV; i++) begin
      run_case(VEC[i], 1'b0, $sformatf("vec%0d", i));
      if (i == 0) begin
        chk("R3 write count", wcnt, 9 * DEPTH);
        chk("R3 read count", rcnt, 13 * DEPTH);
        chk("R3/R4 elem0 first write addr", wlog[0], 0);
        chk("R3/R4 elem0 last write addr", wlog[DEPTH-1], DEPTH - 1);
        chk("R4 elem1 first write addr", wlog[DEPTH], DEPTH - 1);
        chk("R4 elem1 reads stay on cell", rlog[2], DEPTH - 1);
        chk("R4 elem1 second cell", rlog[3], DEPTH - 2);
        chk("R4 elem2 first read addr", rlog[3 * DEPTH], DEPTH - 1);
        chk("R4 elem3 first read addr", rlog[6 * DEPTH], 0);
        chk("R4 elem3 second cell", rlog[6 * DEPTH + 3], 1);
        chk("R4 elem4 first read addr", rlog[9 * DEPTH], 0);
        chk("R4 elem5 first read addr", rlog[12 * DEPTH], 0);
        chk("R4 elem5 last read addr", rlog[13 * DEPTH - 1], DEPTH - 1);
      end
    end

    // R8: start pulse mid-run on a clean RAM; also clears the earlier failure (R7).
    run_case('0, 1'b1, "midstart");
    chk("R9 strobe exclusivity", both_cnt, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule